// File: doc/BRIEF.md
# Segment Register Selection Resolver

This block decides which of four segment registers a memory operand is addressed through, and returns both the two-bit code of that segment and its current base value. The choice comes from the operand's addressing form (the base and index registers it combines), a flag marking the destination operand of a string operation, and any segment-override prefix seen earlier in the same instruction.

A small prefix latch stores the most recent override prefix until the instruction-done strobe. Each addressing form has a default segment. An active override replaces that default, except for two fixed cases. Stack-pointer accesses always go to the stack segment. String destinations always go to the extra segment. Both outputs are registered, so the result for the inputs present at a clock edge appears just after that edge.

Top module: `seg_resolver`

## Requirements
- R1: Form code 1 (stack pointer) selects SS (code 2'b10) whether or not an override is active.
- R2: Form codes 2 (BP), 3 (BP+SI) and 4 (BP+DI) select SS when no override is active.
- R3: Form codes 0 (direct), 5 (BX), 6 (SI), 7 (DI), 8 (BX+SI), 9 (BX+DI) and the unused codes 10 to 15 select DS (code 2'b11) when no override is active.
- R4: With str_dst_i high, the selection is ES (code 2'b00) for every form code and every override.
- R5: With an override active and neither R1 nor R4 applying, the selection is the overriding segment (ES=00, CS=01, SS=10, DS=11).
- R6: A prefix strobe captures pfx_seg_i and takes effect from the following clock edge. When several prefixes arrive before the done strobe, the last one is used.
- R7: The done strobe clears the held override from the following edge. When a prefix strobe arrives in the same cycle as done, the new prefix is kept.
- R8: seg_base_o carries the slice of seg_base_i at bit offset code*BASE_W, taken at the same edge as seg_sel_o.
- R9: Both outputs are registered one clock after their inputs. While rst_ni is low, seg_sel_o and seg_base_o are zero and no override is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| form_i | input | 4 | Addressing form code |
| str_dst_i | input | 1 | Operand is a string destination |
| pfx_valid_i | input | 1 | Override prefix strobe |
| pfx_seg_i | input | 2 | Segment named by the prefix |
| instr_done_i | input | 1 | Current instruction completes |
| seg_base_i | input | 4*BASE_W | Bases of the four segments, code 0 in the low bits |
| seg_sel_o | output | 2 | Selected segment code |
| seg_base_o | output | BASE_W | Base of the selected segment |

## Verification
A wrong prefix latch shows up one cycle after the strobe. An overridable form then resolves to its default segment when it should take the override, or the other way round. The fixed stack and string-destination cases hide this fault, so the bench uses DS-default and SS-default forms after each strobe. A decode or mux fault shows up in the very next registered output, as a wrong code or a base slice that does not match the code.

// File: rtl/seg_res_pkg.sv
package seg_res_pkg;
  localparam int unsigned NUM_SEG = 4;
  localparam int unsigned SEL_W   = $clog2(NUM_SEG);
  localparam int unsigned FORM_W  = 4;

  typedef enum logic [SEL_W-1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_e;

  typedef enum logic [FORM_W-1:0] {
    AM_DIRECT = 4'd0,
    AM_SP     = 4'd1,
    AM_BP     = 4'd2,
    AM_BP_SI  = 4'd3,
    AM_BP_DI  = 4'd4,
    AM_BX     = 4'd5,
    AM_SI     = 4'd6,
    AM_DI     = 4'd7,
    AM_BX_SI  = 4'd8,
    AM_BX_DI  = 4'd9
  } amode_e;

  typedef struct packed {
    logic act;
    seg_e seg;
  } pfx_t;
endpackage

// File: rtl/seg_pfx_latch.sv
module seg_pfx_latch
  import seg_res_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  seg_e seg_i,
  input  logic clr_i,
  output pfx_t pfx_o
);
  pfx_t pfx_q;

  // a new prefix outranks done: it belongs to the next instruction
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pfx_q <= '0;
    else if (set_i)  pfx_q <= '{act: 1'b1, seg: seg_i};
    else if (clr_i)  pfx_q <= '0;
  end

  assign pfx_o = pfx_q;
endmodule

// File: rtl/seg_default_dec.sv
module seg_default_dec
  import seg_res_pkg::*;
(
  input  logic [FORM_W-1:0] form_i,
  input  logic              str_dst_i,
  output seg_e              dflt_o,
  output logic              fixed_o
);
  always_comb begin
    dflt_o  = SEG_DS;
    fixed_o = 1'b0;
    if (str_dst_i) begin
      dflt_o  = SEG_ES;
      fixed_o = 1'b1;
    end else begin
      case (form_i)
        AM_SP: begin
          dflt_o  = SEG_SS;
          fixed_o = 1'b1;
        end
        AM_BP, AM_BP_SI, AM_BP_DI: dflt_o = SEG_SS;
        default:                   dflt_o = SEG_DS;
      endcase
    end
  end
endmodule

// File: rtl/seg_base_mux.sv
module seg_base_mux
  import seg_res_pkg::*;
#(
  parameter int unsigned BASE_W = 16
) (
  input  seg_e                      sel_i,
  input  logic [NUM_SEG*BASE_W-1:0] bases_i,
  output logic [BASE_W-1:0]         base_o
);
  logic [BASE_W-1:0] slice [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_slice
    assign slice[g] = bases_i[g*BASE_W +: BASE_W];
  end

  assign base_o = slice[sel_i];
endmodule

// File: rtl/seg_resolver.sv
module seg_resolver
  import seg_res_pkg::*;
#(
  parameter int unsigned BASE_W = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [FORM_W-1:0]         form_i,
  input  logic                      str_dst_i,
  input  logic                      pfx_valid_i,
  input  logic [SEL_W-1:0]          pfx_seg_i,
  input  logic                      instr_done_i,
  input  logic [NUM_SEG*BASE_W-1:0] seg_base_i,
  output logic [SEL_W-1:0]          seg_sel_o,
  output logic [BASE_W-1:0]         seg_base_o
);
  pfx_t              pfx_q;
  seg_e              dflt;
  logic              fixed;
  seg_e              sel_d;
  logic [BASE_W-1:0] base_d;

  seg_pfx_latch u_pfx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (pfx_valid_i),
    .seg_i  (seg_e'(pfx_seg_i)),
    .clr_i  (instr_done_i),
    .pfx_o  (pfx_q)
  );

  seg_default_dec u_dec (
    .form_i    (form_i),
    .str_dst_i (str_dst_i),
    .dflt_o    (dflt),
    .fixed_o   (fixed)
  );

  assign sel_d = (pfx_q.act && !fixed) ? pfx_q.seg : dflt;

  seg_base_mux #(.BASE_W(BASE_W)) u_mux (
    .sel_i   (sel_d),
    .bases_i (seg_base_i),
    .base_o  (base_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_sel_o  <= '0;
      seg_base_o <= '0;
    end else begin
      seg_sel_o  <= sel_d;
      seg_base_o <= base_d;
    end
  end
endmodule

// File: rtl/seg_resolver_chk.sv
module seg_resolver_chk
  import seg_res_pkg::*;
#(
  parameter int unsigned BASE_W = 16
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [FORM_W-1:0]         form_i,
  input logic                      str_dst_i,
  input logic                      pfx_valid_i,
  input logic [SEL_W-1:0]          pfx_seg_i,
  input logic                      instr_done_i,
  input logic [NUM_SEG*BASE_W-1:0] seg_base_i,
  input logic [SEL_W-1:0]          seg_sel_o,
  input logic [BASE_W-1:0]         seg_base_o,
  input pfx_t                      pfx_q
);
  logic                      seen;
  logic [NUM_SEG*BASE_W-1:0] bases_q;
  logic [FORM_W-1:0]         form_q;
  logic                      str_q;
  pfx_t                      pfx_d1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen    <= 1'b0;
      bases_q <= '0;
      form_q  <= '0;
      str_q   <= 1'b0;
      pfx_d1  <= '0;
    end else begin
      seen    <= 1'b1;
      bases_q <= seg_base_i;
      form_q  <= form_i;
      str_q   <= str_dst_i;
      pfx_d1  <= pfx_q;
    end
  end

  p_sp_ss_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && !str_q && form_q == AM_SP) |-> seg_sel_o == SEG_SS);

  p_bp_ss_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && !str_q && !pfx_d1.act &&
     (form_q == AM_BP || form_q == AM_BP_SI || form_q == AM_BP_DI))
    |-> seg_sel_o == SEG_SS);

  p_ds_dflt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && !str_q && !pfx_d1.act && form_q != AM_SP && form_q != AM_BP &&
     form_q != AM_BP_SI && form_q != AM_BP_DI) |-> seg_sel_o == SEG_DS);

  p_str_es_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && str_q) |-> seg_sel_o == SEG_ES);

  p_override_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && !str_q && form_q != AM_SP && pfx_d1.act) |-> seg_sel_o == pfx_d1.seg);

  p_pfx_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pfx_valid_i |=> (pfx_q.act && pfx_q.seg == $past(pfx_seg_i)));

  p_pfx_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_done_i && !pfx_valid_i) |=> !pfx_q.act);

  p_base_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen |-> seg_base_o == bases_q[seg_sel_o*BASE_W +: BASE_W]);

  p_reset_r9: assert property (@(posedge clk_i)
    !rst_ni |-> (seg_sel_o == '0 && seg_base_o == '0 && !pfx_q.act));
endmodule

bind seg_resolver seg_resolver_chk #(.BASE_W(BASE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .form_i       (form_i),
  .str_dst_i    (str_dst_i),
  .pfx_valid_i  (pfx_valid_i),
  .pfx_seg_i    (pfx_seg_i),
  .instr_done_i (instr_done_i),
  .seg_base_i   (seg_base_i),
  .seg_sel_o    (seg_sel_o),
  .seg_base_o   (seg_base_o),
  .pfx_q        (pfx_q)
);

// File: tb/seg_resolver_test.sv
module seg_resolver_test;
  localparam int CLK_PERIOD = 10;
  localparam int BASE_W     = 16;

  logic                  clk = 1'b0;
  logic                  rst_ni = 1'b0;
  logic [3:0]            form_i = '0;
  logic                  str_dst_i = 1'b0;
  logic                  pfx_valid_i = 1'b0;
  logic [1:0]            pfx_seg_i = '0;
  logic                  instr_done_i = 1'b0;
  logic [4*BASE_W-1:0]   seg_base_i = '0;
  logic [1:0]            seg_sel_o;
  logic [BASE_W-1:0]     seg_base_o;

  int checks = 0;
  int fails  = 0;

  logic       m_act = 1'b0;
  logic [1:0] m_seg = '0;
  logic       have_exp = 1'b0;
  logic [1:0] e_sel;
  logic [BASE_W-1:0] e_base;
  string      e_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_resolver #(.BASE_W(BASE_W)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .form_i       (form_i),
    .str_dst_i    (str_dst_i),
    .pfx_valid_i  (pfx_valid_i),
    .pfx_seg_i    (pfx_seg_i),
    .instr_done_i (instr_done_i),
    .seg_base_i   (seg_base_i),
    .seg_sel_o    (seg_sel_o),
    .seg_base_o   (seg_base_o)
  );

  function automatic logic [1:0] ref_sel(input logic [3:0] f, input logic s,
                                         input logic act, input logic [1:0] sg);
    if (s) return 2'd0;
    if (f == 4'd1) return 2'd2;
    if (act) return sg;
    if (f >= 4'd2 && f <= 4'd4) return 2'd2;
    return 2'd3;
  endfunction

  function automatic string ref_tag(input logic [3:0] f, input logic s, input logic act);
    if (s) return "R4";
    if (f == 4'd1) return "R1";
    if (act) return "R5";
    if (f >= 4'd2 && f <= 4'd4) return "R2";
    return "R3";
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_pending();
    if (have_exp) begin
      check(e_tag, 64'(seg_sel_o), 64'(e_sel));
      check("R8", 64'(seg_base_o), 64'(e_base));
    end
  endtask

  task automatic step(input logic [3:0] f, input logic s, input logic pv,
                      input logic [1:0] ps, input logic d, input string tag = "");
    @(negedge clk);
    check_pending();
    form_i       = f;
    str_dst_i    = s;
    pfx_valid_i  = pv;
    pfx_seg_i    = ps;
    instr_done_i = d;
    seg_base_i   = {$urandom(), $urandom()};
    e_sel        = ref_sel(f, s, m_act, m_seg);
    e_base       = seg_base_i[e_sel*BASE_W +: BASE_W];
    e_tag        = (tag != "") ? tag : ref_tag(f, s, m_act);
    have_exp     = 1'b1;
    if (pv) begin
      m_act = 1'b1;
      m_seg = ps;
    end else if (d) begin
      m_act = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    seg_base_i = 64'hdead_beef_cafe_f00d;
    pfx_valid_i = 1'b1;
    pfx_seg_i = 2'd1;
    repeat (3) @(negedge clk);
    check("R9", 64'(seg_sel_o), 64'd0);
    check("R9", 64'(seg_base_o), 64'd0);
    pfx_valid_i = 1'b0;
    rst_ni = 1'b1;

    // R9: no override held after reset, BX resolves to DS
    step(4'd5, 1'b0, 1'b0, 2'd0, 1'b0, "R9");

    // R1 R2 R3: every form, no override
    for (int f = 0; f < 16; f++) step(4'(f), 1'b0, 1'b0, 2'd0, 1'b0);

    // R5 and R1: every form under every override
    for (int ov = 0; ov < 4; ov++)
      for (int f = 0; f < 10; f++) begin
        step(4'(f), 1'b0, 1'b1, 2'(ov), 1'b0);
        step(4'(f), 1'b0, 1'b0, 2'd0, 1'b1);
      end

    // R4: string destination ignores a held DS override
    step(4'd6, 1'b0, 1'b1, 2'd3, 1'b0);
    step(4'd7, 1'b1, 1'b0, 2'd0, 1'b0, "R4");
    step(4'd2, 1'b1, 1'b0, 2'd0, 1'b1, "R4");

    // R6: last of two prefixes wins
    step(4'd5, 1'b0, 1'b1, 2'd2, 1'b0);
    step(4'd5, 1'b0, 1'b1, 2'd1, 1'b0, "R6");
    step(4'd5, 1'b0, 1'b0, 2'd0, 1'b0, "R6");

    // R7: prefix together with done is kept
    step(4'd5, 1'b0, 1'b1, 2'd0, 1'b1);
    step(4'd3, 1'b0, 1'b0, 2'd0, 1'b0, "R7");
    // R7: done alone clears, BX back to DS, BP back to SS
    step(4'd5, 1'b0, 1'b0, 2'd0, 1'b1);
    step(4'd5, 1'b0, 1'b0, 2'd0, 1'b0, "R7");
    step(4'd2, 1'b0, 1'b0, 2'd0, 1'b0, "R7");

    // random mix
    for (int i = 0; i < 3000; i++)
      step(4'($urandom_range(15, 0)), ($urandom_range(4, 0) == 0),
           ($urandom_range(3, 0) == 0), 2'($urandom_range(3, 0)),
           ($urandom_range(2, 0) == 0));

    @(negedge clk);
    check_pending();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule